// File: doc/BRIEF.md
# Cascadable Byte Scan Multiplexer

This block presents a wide latched word on a narrow shared bus, one byte per scan strobe, starting with the least significant byte. A scan reset copies the incoming word into an internal holding register and puts the scanner back on the lowest byte. After that, each falling edge of the scan strobe moves the scanner one byte higher, but only while the unit is enabled. The bus is driven only while the strobe is high, so a host can raise the strobe to ask for the next byte and lower it to free the bus.

After the top byte has been scanned, the scanner moves into a terminal state. It stops driving the bus and pulls its chain output low. That output feeds the active-low enable of the next unit, so several units can share one bus, one strobe and one scan reset. Together they deliver their bytes back to back, and only one unit drives the bus at any time. All inputs are sampled on a system clock. The three-state driver is modelled as an output-enable signal. Whenever the output-enable is low, the data output is held at zero.

Top module: `byte_scan_mux`

## Requirements
- R1: During and after system reset (`rst_n` low), `data_oe_o` is low whenever `scan_i` is low, `chain_o` is high, the scanner points at byte 0 and the held word is all zeros.
- R2: A clock edge that samples `scan_rst_n_i` low does three things: it copies `word_i` into the held word, returns the scanner to byte 0 and drives `chain_o` high.
- R3: A falling scan edge is a clock edge at which `scan_i` is low and was high at the previous edge. When such an edge is sampled with `enable_n_i` low, the scanner moves up one byte, effective from that edge.
- R4: The byte at position k (k = 0..4) is `word[8k+7:8k]` of the held word. The bus shows positions 0, 1, 2, 3, 4 in that order.
- R5: The fifth advance puts the scanner in the terminal state. In that state `chain_o` is low, `data_oe_o` is low, and further scan edges change nothing until a scan reset.
- R6: `data_oe_o` is high exactly when `enable_n_i` is low, `scan_i` is high and the scanner is not terminal. This follows the inputs combinationally, in the same cycle.
- R7: `data_o` is all zeros whenever `data_oe_o` is low. Otherwise it carries the byte at the current position.
- R8: A falling scan edge sampled while `enable_n_i` is high is ignored, and the position does not change.
- R9: When a scan reset and a falling scan edge are sampled at the same edge, the scan reset wins and the scanner ends on byte 0.
- R10: With three units chained through `chain_o` into the next `enable_n_i`, the shared bus carries exactly 15 bytes in unit order, least significant byte first, and at most one unit drives at a time.
- R11: Changes of `word_i` without a scan reset do not alter the bytes presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the environment |
| scan_i | input | 1 | Scan strobe; high asks for the current byte, falling edge advances |
| scan_rst_n_i | input | 1 | Active-low scan reset and word load |
| enable_n_i | input | 1 | Active-low unit enable (from the previous unit's `chain_o`) |
| word_i | input | 40 | Word to be held on scan reset |
| data_o | output | 8 | Presented byte, zero when not driving |
| data_oe_o | output | 1 | Bus drive enable |
| chain_o | output | 1 | High until terminal state, low while terminal |

## Verification
The output-enable and data byte are combinational from the inputs and the position register. The bench therefore checks them 1 ns after it drives `scan_i` high, in the same cycle. A position change takes effect at the one clock edge that samples the low strobe following a high strobe. Scan reset loading acts at the single edge that samples `scan_rst_n_i` low. Every such check is made 1 ns after that edge, once both the register and the combinational outputs have settled. The bench drives inputs only 1 ns after a rising edge, so no input changes while it is being sampled.

// File: rtl/byte_scan_pkg.sv
`timescale 1ns/1ps
package byte_scan_pkg;
  localparam int unsigned DEF_BYTE_W    = 8;
  localparam int unsigned DEF_NUM_BYTES = 5;

  // width of a position counter that must also hold the terminal value
  function automatic int unsigned pos_width(input int unsigned n_bytes);
    return $clog2(n_bytes + 1);
  endfunction
endpackage

// File: rtl/scan_edge_det.sv
`timescale 1ns/1ps
module scan_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_i;
  end

  assign fall_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/scan_seq.sv
`timescale 1ns/1ps
module scan_seq #(
  parameter int unsigned NUM_BYTES = 5,
  parameter int unsigned POS_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [POS_W-1:0] pos_o,
  output logic             at_end_o
);
  localparam logic [POS_W-1:0] END_POS = POS_W'(NUM_BYTES);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  assign at_end_o = (pos_q == END_POS);

  always_comb begin
    pos_en = 1'b0;
    pos_d  = pos_q;
    if (load_i) begin
      pos_en = 1'b1;
      pos_d  = '0;
    end else if (step_i && !at_end_o) begin
      pos_en = 1'b1;
      pos_d  = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/word_hold.sv
`timescale 1ns/1ps
module word_hold #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 5,
  parameter int unsigned POS_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [BYTE_W*NUM_BYTES-1:0] word_i,
  input  logic [POS_W-1:0]            sel_i,
  output logic [BYTE_W-1:0]           byte_o
);
  logic [BYTE_W-1:0] slot_q [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q[g] <= '0;
      else if (load_i) slot_q[g] <= word_i[g*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (sel_i == POS_W'(k)) byte_o = slot_q[k];
    end
  end
endmodule

// File: rtl/byte_scan_mux.sv
`timescale 1ns/1ps
module byte_scan_mux #(
  parameter int unsigned BYTE_W    = byte_scan_pkg::DEF_BYTE_W,
  parameter int unsigned NUM_BYTES = byte_scan_pkg::DEF_NUM_BYTES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scan_i,
  input  logic                        scan_rst_n_i,
  input  logic                        enable_n_i,
  input  logic [BYTE_W*NUM_BYTES-1:0] word_i,
  output logic [BYTE_W-1:0]           data_o,
  output logic                        data_oe_o,
  output logic                        chain_o
);
  localparam int unsigned POS_W = byte_scan_pkg::pos_width(NUM_BYTES);

  logic             scan_fall;
  logic             load;
  logic             step;
  logic             at_end;
  logic [POS_W-1:0] pos;
  logic [BYTE_W-1:0] cur_byte;

  assign load = ~scan_rst_n_i;
  assign step = scan_fall & ~enable_n_i;

  scan_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (scan_i),
    .fall_o   (scan_fall)
  );

  scan_seq #(.NUM_BYTES(NUM_BYTES), .POS_W(POS_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .pos_o    (pos),
    .at_end_o (at_end)
  );

  word_hold #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .POS_W(POS_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .word_i (word_i),
    .sel_i  (pos),
    .byte_o (cur_byte)
  );

  assign data_oe_o = ~enable_n_i & scan_i & ~at_end;
  assign data_o    = data_oe_o ? cur_byte : '0;
  assign chain_o   = ~at_end;
endmodule

// File: rtl/byte_scan_mux_chk.sv
`timescale 1ns/1ps
module byte_scan_mux_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_i,
  input logic              scan_rst_n_i,
  input logic              enable_n_i,
  input logic [BYTE_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              chain_o
);
  AST_OE_NEEDS_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (!enable_n_i && scan_i)); // R6

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_o |-> (data_o == '0)); // R7

  AST_END_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_o |-> !data_oe_o); // R5

  AST_END_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_o && scan_rst_n_i) |=> !chain_o); // R5

  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_rst_n_i |=> chain_o); // R9

  AST_FROZEN_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_n_i && scan_rst_n_i) |=> $stable(chain_o)); // R8
endmodule

bind byte_scan_mux byte_scan_mux_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .scan_i       (scan_i),
  .scan_rst_n_i (scan_rst_n_i),
  .enable_n_i   (enable_n_i),
  .data_o       (data_o),
  .data_oe_o    (data_oe_o),
  .chain_o      (chain_o)
);

// File: tb/byte_scan_mux_tb_top.sv
`timescale 1ns/1ps
module byte_scan_mux_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, scan, srst_n, en_n;
  logic [39:0] wi [3];
  logic [39:0] lw [3];
  logic [7:0]  d [3];
  logic        oe [3];
  logic        ch [3];
  int          checks = 0;
  int          fails  = 0;
  int          g      = 0;

  byte_scan_mux dut_i (.clk(clk), .rst_n(rst_n), .scan_i(scan), .scan_rst_n_i(srst_n),
    .enable_n_i(en_n), .word_i(wi[0]), .data_o(d[0]), .data_oe_o(oe[0]), .chain_o(ch[0]));
  byte_scan_mux dut_b (.clk(clk), .rst_n(rst_n), .scan_i(scan), .scan_rst_n_i(srst_n),
    .enable_n_i(ch[0]), .word_i(wi[1]), .data_o(d[1]), .data_oe_o(oe[1]), .chain_o(ch[1]));
  byte_scan_mux dut_c (.clk(clk), .rst_n(rst_n), .scan_i(scan), .scan_rst_n_i(srst_n),
    .enable_n_i(ch[1]), .word_i(wi[2]), .data_o(d[2]), .data_oe_o(oe[2]), .chain_o(ch[2]));

  function automatic logic [7:0] exp_byte(input logic [39:0] w, input int k);
    return w[8*k +: 8];
  endfunction

  function automatic logic [39:0] rnd_word();
    return {8'($urandom), 32'($urandom)};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // the unit owning position g is enabled unless it is the first and en_n is high
  function automatic bit slot_live();
    return (g < 15) && !(g < 5 && en_n);
  endfunction

  task automatic bus_check(input string tag);
    int          n;
    logic [7:0]  bus;
    logic [7:0]  expb;
    n    = int'(oe[0]) + int'(oe[1]) + int'(oe[2]);
    bus  = d[0] | d[1] | d[2];
    expb = slot_live() ? exp_byte(lw[g/5], g%5) : 8'h00;
    chk(n == (slot_live() ? 1 : 0), {tag, " R10 drivers"}, 64'(n), 64'(slot_live()));
    chk(bus == expb, {tag, " R4 R7 bus byte"}, 64'(bus), 64'(expb));
  endtask

  task automatic pulse(input string tag);
    scan = 1'b1;
    #1;
    bus_check(tag);
    tick();
    scan = 1'b0;
    tick();
    if (slot_live()) g++;
    chk(!(oe[0] | oe[1] | oe[2]), "R6 strobe low", 64'({oe[0], oe[1], oe[2]}), 64'(0));
  endtask

  task automatic reload(input bit fresh);
    for (int u = 0; u < 3; u++) begin
      if (fresh) wi[u] = rnd_word();
      lw[u] = wi[u];
    end
    srst_n = 1'b0;
    tick();
    srst_n = 1'b1;
    g = 0;
    chk(ch[0] && ch[1] && ch[2], "R2 chain high after load", 64'({ch[0], ch[1], ch[2]}), 64'h7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; scan = 1'b0; srst_n = 1'b1; en_n = 1'b0;
    for (int u = 0; u < 3; u++) begin wi[u] = 40'h0; lw[u] = 40'h0; end
    repeat (3) tick();
    // R1 reset state
    chk(!(oe[0] | oe[1] | oe[2]), "R1 no drive in reset", 64'({oe[0], oe[1], oe[2]}), 64'(0));
    chk(ch[0] && ch[1] && ch[2], "R1 chain high in reset", 64'({ch[0], ch[1], ch[2]}), 64'h7);
    rst_n = 1'b1;
    tick();
    scan = 1'b1;
    #1;
    chk(oe[0] && d[0] == 8'h00, "R1 byte0 of cleared word", 64'({oe[0], d[0]}), 64'h100);
    scan = 1'b0;
    tick();
    tick();
    g = 1;
    reload(1'b1);

    // R3 R4 R10 full cascade: 15 bytes then terminal
    for (int i = 0; i < 16; i++) pulse("R3 cascade");
    chk(g == 15, "R10 byte count", 64'(g), 64'd15);
    chk(!ch[0] && !ch[1] && !ch[2], "R5 all terminal", 64'({ch[0], ch[1], ch[2]}), 64'h0);
    pulse("R5 after end");
    chk(!ch[2], "R5 terminal holds", 64'(ch[2]), 64'h0);

    // R8 edges ignored while disabled
    reload(1'b1);
    en_n = 1'b1;
    for (int i = 0; i < 3; i++) pulse("R8 disabled");
    en_n = 1'b0;
    pulse("R8 resumes at byte0");

    // R11 input word changes without reload
    for (int u = 0; u < 3; u++) wi[u] = rnd_word();
    tick();
    pulse("R11 held word");
    pulse("R11 held word");

    // R9 reload and falling edge at the same clock edge
    scan = 1'b1;
    tick();
    for (int u = 0; u < 3; u++) begin wi[u] = rnd_word(); lw[u] = wi[u]; end
    scan = 1'b0;
    srst_n = 1'b0;
    tick();
    srst_n = 1'b1;
    g = 0;
    pulse("R9 reload wins");

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int n;
      reload(1'b1);
      n = $urandom_range(0, 17);
      for (int p = 0; p < n; p++) begin
        en_n = ($urandom_range(0, 3) == 0);
        pulse("R3 random");
      end
      en_n = 1'b0;
      #1;
      chk(ch[0] == (g < 5), "R5 chain A", 64'(ch[0]), 64'(g < 5));
      chk(ch[2] == (g < 15), "R5 chain C", 64'(ch[2]), 64'(g < 15));
    end
    report();
  end
endmodule